// File: doc/BRIEF.md
# Prioritised Interrupt Dispatcher with Standby Wake

This block collects interrupt events from a set of peripheral sources plus one non-maskable source and presents them to a processor core one at a time. Each maskable source owns a single pending bit. A one-cycle event pulse from the peripheral sets it, and software can set or clear it through strobe vectors. Software also writes a per-source mask vector and a per-source priority bit (0 = low level, 1 = high level). The non-maskable source sits above both levels and ignores the mask and the global enable.

The core sees a request-valid signal and a vector index. It answers with a one-cycle acknowledge, which clears the chosen pending bit, turns the global enable off and records the level as in service. A return strobe closes the innermost service level and restores the enable value that was captured at its acknowledge. In-service levels nest strictly upward, so the record is a stack with at most one entry per level. Separately, a wake output rises whenever any unmasked or non-maskable event is pending, whatever the global enable says. A standby controller can use it to leave low-power mode.

All state is registered. Every output is a function of registered state only, so the effect of an input applied before a rising edge is visible right after that edge.

Top module: `irq_hub`

## Requirements
- R1: A peripheral pulse sets the source's pending bit. Several pulses before acknowledge leave one pending bit, so one acknowledge removes the whole event and the source is not offered again.
- R2: `sw_set` and `sw_clr` set and clear pending bits. In one cycle, a set (software or peripheral) wins over a software clear of the same bit, and also over the clear caused by an acknowledge of that source.
- R3: A masked source's pending bit is kept but is neither offered nor counted for wake. After a mask write that unmasks it, the source counts for wake and dispatch from the next cycle on.
- R4: `wake` is high exactly when some unmasked maskable bit or the non-maskable bit is pending, independent of the global enable.
- R5: A maskable source is offered only while the global enable `ie_o` is 1. With the enable at 0, such requests stay pending and `irq_valid` stays low.
- R6: Among eligible requests, high level beats low level, and within a level the lowest source index wins. `irq_vec` gives that index. The non-maskable source uses vector `N_SRC`.
- R7: A request is eligible only if its rank is strictly above the innermost in-service rank. Ranks are none = 0, low = 1, high = 2, non-maskable = 3.
- R8: An acknowledge while `irq_valid` is high clears the offered pending bit, forces `ie_o` to 0 on the next cycle and pushes the offered rank as in service. The acknowledge takes precedence over `ie_set` in the same cycle.
- R9: `reti` pops the innermost in-service rank and restores `ie_o` to the value it had at that rank's acknowledge. Nested levels unwind one per strobe.
- R10: The non-maskable source is offered whenever it is pending and not itself in service, regardless of mask and enable. While it is in service, nothing is offered even if `ie_set` raises the enable.
- R11: After reset, all pending bits are 0, all masks are 1, all priority bits are 0, the enable is 0, nothing is in service, and `irq_valid` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | N_SRC | Peripheral event pulses, one per source |
| nmi_pulse | input | 1 | Non-maskable event pulse |
| sw_set | input | N_SRC | Software set strobes for pending bits |
| sw_clr | input | N_SRC | Software clear strobes for pending bits |
| mask_wr | input | 1 | Write strobe for the mask vector |
| mask_wdata | input | N_SRC | New mask vector (1 = masked) |
| prio_wr | input | 1 | Write strobe for the priority vector |
| prio_wdata | input | N_SRC | New priority vector (1 = high level) |
| ie_set | input | 1 | Turn global enable on |
| ie_clr | input | 1 | Turn global enable off (wins over ie_set) |
| irq_valid | output | 1 | A request is offered to the core |
| irq_vec | output | $clog2(N_SRC+1) | Index of the offered source, N_SRC for non-maskable |
| irq_ack | input | 1 | Core accepts the offered request |
| reti | input | 1 | Return-from-interrupt strobe |
| wake | output | 1 | Standby wake request |
| ie_o | output | 1 | Current global enable |
| pend | output | N_SRC+1 | Pending bits; bit N_SRC is the non-maskable one |

## Verification
The properties assume two things about the core. It raises `irq_ack` only in a cycle where `irq_valid` is high, and it never raises `irq_ack` and `reti` together. Both assumptions are also stated as checked properties. The stimulus respects them because the bench decides on acknowledge from its own model of the offer and sends a return only while its model holds an in-service level, and never in an acknowledge cycle. All other inputs, including same-cycle set/clear collisions and mask and priority rewrites, are driven freely. The bench's random mix and its directed cases reach these collisions on purpose.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    // Service rank: 0 = idle, then low, high, non-maskable
    typedef logic [1:0] rank_t;

    localparam rank_t RANK_NONE = 2'd0;
    localparam rank_t RANK_LO   = 2'd1;
    localparam rank_t RANK_HI   = 2'd2;
    localparam rank_t RANK_NMI  = 2'd3;

    localparam int NUM_RANKS = 3;

endpackage

// File: rtl/irq_hub_pick.sv
// Priority resolver: picks the request to offer from the current state
module irq_hub_pick
    import irq_hub_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] prio,
    input  logic             nmi_req,
    input  logic             ie,
    input  rank_t            cur_rank,
    output logic             valid,
    output logic [IDX_W-1:0] vec,
    output rank_t            rank
);

    logic             hi_hit;
    logic             lo_hit;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;

    // Scan downward so the lowest index is written last
    always_comb begin
        hi_hit = 1'b0;
        lo_hit = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i] && prio[i]) begin
                hi_hit = 1'b1;
                hi_idx = IDX_W'(i);
            end
            if (req[i] && !prio[i]) begin
                lo_hit = 1'b1;
                lo_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        valid = 1'b0;
        vec   = '0;
        rank  = RANK_NONE;
        if (nmi_req && cur_rank != RANK_NMI) begin
            valid = 1'b1;
            vec   = IDX_W'(N_SRC);
            rank  = RANK_NMI;
        end else if (ie && hi_hit && cur_rank < RANK_HI) begin
            valid = 1'b1;
            vec   = hi_idx;
            rank  = RANK_HI;
        end else if (ie && lo_hit && cur_rank < RANK_LO) begin
            valid = 1'b1;
            vec   = lo_idx;
            rank  = RANK_LO;
        end
    end

endmodule

// File: rtl/irq_hub_nest.sv
// In-service record: one active bit and one saved-enable bit per rank
module irq_hub_nest
    import irq_hub_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  rank_t push_rank,
    input  logic  push_ie,
    input  logic  pop,
    output rank_t cur_rank,
    output logic  pop_ie
);

    typedef struct packed {
        logic [NUM_RANKS-1:0] act;
        logic [NUM_RANKS-1:0] sav;
    } nest_t;

    nest_t nest_d, nest_q;

    // Innermost level = highest active rank
    always_comb begin
        cur_rank = RANK_NONE;
        pop_ie   = 1'b0;
        for (int k = 0; k < NUM_RANKS; k++) begin
            if (nest_q.act[k]) begin
                cur_rank = rank_t'(k + 1);
                pop_ie   = nest_q.sav[k];
            end
        end
    end

    always_comb begin
        nest_d = nest_q;
        for (int k = 0; k < NUM_RANKS; k++) begin
            if (push && push_rank == rank_t'(k + 1)) begin
                nest_d.act[k] = 1'b1;
                nest_d.sav[k] = push_ie;
            end else if (!push && pop && cur_rank == rank_t'(k + 1)) begin
                nest_d.act[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nest_q <= '0;
        end else begin
            nest_q <= nest_d;
        end
    end

endmodule

// File: rtl/irq_hub.sv
// Interrupt dispatcher top: pending bits, mask, priority, enable
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter  int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_pulse,
    input  logic             nmi_pulse,
    input  logic [N_SRC-1:0] sw_set,
    input  logic [N_SRC-1:0] sw_clr,
    input  logic             mask_wr,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic             prio_wr,
    input  logic [N_SRC-1:0] prio_wdata,
    input  logic             ie_set,
    input  logic             ie_clr,
    output logic             irq_valid,
    output logic [IDX_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             reti,
    output logic             wake,
    output logic             ie_o,
    output logic [N_SRC:0]   pend
);

    typedef struct packed {
        logic [N_SRC-1:0] flag;
        logic             nmi;
        logic [N_SRC-1:0] mask;
        logic [N_SRC-1:0] prio;
        logic             ie;
    } hub_t;

    hub_t st_d, st_q;

    logic             offer_valid;
    logic [IDX_W-1:0] offer_vec;
    rank_t            offer_rank;
    rank_t            cur_rank;
    logic             pop_ie;
    logic             take;
    logic             pop;
    logic [N_SRC-1:0] live_req;

    assign live_req = st_q.flag & ~st_q.mask;
    assign take     = irq_ack & offer_valid;
    assign pop      = reti & ~take;

    irq_hub_pick #(
        .N_SRC(N_SRC),
        .IDX_W(IDX_W)
    ) u_pick (
        .req     (live_req),
        .prio    (st_q.prio),
        .nmi_req (st_q.nmi),
        .ie      (st_q.ie),
        .cur_rank(cur_rank),
        .valid   (offer_valid),
        .vec     (offer_vec),
        .rank    (offer_rank)
    );

    irq_hub_nest u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .push_rank(offer_rank),
        .push_ie  (st_q.ie),
        .pop      (pop),
        .cur_rank (cur_rank),
        .pop_ie   (pop_ie)
    );

    always_comb begin
        st_d = st_q;

        // Pending bits: clears first, sets last so a set wins
        for (int i = 0; i < N_SRC; i++) begin
            if (sw_clr[i]) begin
                st_d.flag[i] = 1'b0;
            end
            if (take && offer_vec == IDX_W'(i)) begin
                st_d.flag[i] = 1'b0;
            end
            if (sw_set[i] || src_pulse[i]) begin
                st_d.flag[i] = 1'b1;
            end
        end
        if (take && offer_vec == IDX_W'(N_SRC)) begin
            st_d.nmi = 1'b0;
        end
        if (nmi_pulse) begin
            st_d.nmi = 1'b1;
        end

        if (mask_wr) begin
            st_d.mask = mask_wdata;
        end
        if (prio_wr) begin
            st_d.prio = prio_wdata;
        end

        // Global enable: acknowledge and return override core writes
        if (ie_set) begin
            st_d.ie = 1'b1;
        end
        if (ie_clr) begin
            st_d.ie = 1'b0;
        end
        if (take) begin
            st_d.ie = 1'b0;
        end else if (pop && cur_rank != RANK_NONE) begin
            st_d.ie = pop_ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= '0;
            st_q.nmi  <= 1'b0;
            st_q.mask <= '1;
            st_q.prio <= '0;
            st_q.ie   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_valid = offer_valid;
    assign irq_vec   = offer_vec;
    assign wake      = (|live_req) | st_q.nmi;
    assign ie_o      = st_q.ie;
    assign pend      = {st_q.nmi, st_q.flag};

endmodule

// File: rtl/irq_hub_chk.sv
// Property checker for irq_hub, attached by bind
module irq_hub_chk #(
    parameter int N_SRC = 8,
    parameter int IDX_W = $clog2(N_SRC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_pulse,
    input logic             nmi_pulse,
    input logic [N_SRC-1:0] sw_set,
    input logic             irq_valid,
    input logic [IDX_W-1:0] irq_vec,
    input logic             irq_ack,
    input logic             reti,
    input logic             wake,
    input logic             ie_o,
    input logic [N_SRC:0]   pend
);

    logic nmi_busy;

    // Tracks whether the non-maskable level is open; it is always innermost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_busy <= 1'b0;
        end else if (irq_ack && irq_valid && irq_vec == IDX_W'(N_SRC)) begin
            nmi_busy <= 1'b1;
        end else if (reti) begin
            nmi_busy <= 1'b0;
        end
    end

    // input assumption: the core acknowledges only an offered request
    ack_only_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> irq_valid);

    // input assumption: acknowledge and return never coincide
    no_ack_with_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && reti));

    // R8
    ack_drops_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid) |=> !ie_o);

    // R4
    nmi_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend[N_SRC] |-> wake);

    // R4
    offer_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> wake);

    // R5
    maskable_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_vec != IDX_W'(N_SRC)) |-> ie_o);

    // R10
    nmi_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_busy |-> !irq_valid);

    // R1
    nmi_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid && irq_vec == IDX_W'(N_SRC) && !nmi_pulse)
        |=> !pend[N_SRC]);

    // R6
    vec_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vec <= IDX_W'(N_SRC)));

    for (genvar g = 0; g < N_SRC; g++) begin : g_set
        // R2
        set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_set[g] || src_pulse[g]) |=> pend[g]);
    end

endmodule

bind irq_hub irq_hub_chk #(
    .N_SRC(N_SRC)
) u_irq_hub_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_pulse(src_pulse),
    .nmi_pulse(nmi_pulse),
    .sw_set   (sw_set),
    .irq_valid(irq_valid),
    .irq_vec  (irq_vec),
    .irq_ack  (irq_ack),
    .reti     (reti),
    .wake     (wake),
    .ie_o     (ie_o),
    .pend     (pend)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;

    localparam int N          = 8;
    localparam int W          = $clog2(N + 1);
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYC   = 4000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_pulse = '0;
    logic         nmi_pulse = 1'b0;
    logic [N-1:0] sw_set = '0;
    logic [N-1:0] sw_clr = '0;
    logic         mask_wr = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic         prio_wr = 1'b0;
    logic [N-1:0] prio_wdata = '0;
    logic         ie_set = 1'b0;
    logic         ie_clr = 1'b0;
    logic         irq_ack = 1'b0;
    logic         reti = 1'b0;
    logic         irq_valid;
    logic [W-1:0] irq_vec;
    logic         wake;
    logic         ie_o;
    logic [N:0]   pend;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    irq_hub #(.N_SRC(N)) i_irq_hub (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .nmi_pulse(nmi_pulse),
        .sw_set(sw_set), .sw_clr(sw_clr), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .prio_wr(prio_wr), .prio_wdata(prio_wdata), .ie_set(ie_set), .ie_clr(ie_clr),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ack(irq_ack), .reti(reti),
        .wake(wake), .ie_o(ie_o), .pend(pend)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model built from the requirements
    logic [N:0]   m_flag = '0;
    logic [N-1:0] m_mask = '1;
    logic [N-1:0] m_prio = '0;
    logic         m_ie   = 1'b0;
    logic [2:0]   m_act  = '0;
    logic [2:0]   m_sav  = '0;

    function automatic int m_cur();
        if (m_act[2]) return 3;
        if (m_act[1]) return 2;
        if (m_act[0]) return 1;
        return 0;
    endfunction

    function automatic int m_rank(int v);
        if (v == N) return 3;
        return m_prio[v] ? 2 : 1;
    endfunction

    function automatic int m_pick();
        int cur = m_cur();
        if (m_flag[N] && cur < 3) return N;
        if (m_ie && cur < 2)
            for (int i = 0; i < N; i++)
                if (m_flag[i] && !m_mask[i] && m_prio[i]) return i;
        if (m_ie && cur < 1)
            for (int i = 0; i < N; i++)
                if (m_flag[i] && !m_mask[i] && !m_prio[i]) return i;
        return -1;
    endfunction

    function automatic int m_wake();
        return ((|(m_flag[N-1:0] & ~m_mask)) || m_flag[N]) ? 1 : 0;
    endfunction

    task automatic model_step();
        int         pick = m_pick();
        bit         take = irq_ack && (pick >= 0);
        logic [N:0] nf   = m_flag;
        logic       ni   = m_ie;
        for (int i = 0; i < N; i++) begin
            if (sw_clr[i]) nf[i] = 1'b0;
            if (take && pick == i) nf[i] = 1'b0;
            if (sw_set[i] || src_pulse[i]) nf[i] = 1'b1;
        end
        if (take && pick == N) nf[N] = 1'b0;
        if (nmi_pulse) nf[N] = 1'b1;
        if (ie_set) ni = 1'b1;
        if (ie_clr) ni = 1'b0;
        if (take) begin
            int r = m_rank(pick);
            m_act[r-1] = 1'b1;
            m_sav[r-1] = m_ie;
            ni = 1'b0;
        end else if (reti && m_cur() > 0) begin
            int k = m_cur() - 1;
            ni = m_sav[k];
            m_act[k] = 1'b0;
        end
        if (mask_wr) m_mask = mask_wdata;
        if (prio_wr) m_prio = prio_wdata;
        m_flag = nf;
        m_ie   = ni;
    endtask

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int pick = m_pick();
        chk("R1 R2 R3 pend", int'(pend), int'(m_flag));
        chk("R4 wake", int'(wake), m_wake());
        chk("R5 R7 R10 valid", int'(irq_valid), (pick >= 0) ? 1 : 0);
        if (pick >= 0) chk("R6 vec", int'(irq_vec), pick);
        chk("R8 R9 ie", int'(ie_o), int'(m_ie));
    endtask

    // One clock: edge, model update, strobes dropped, outputs compared
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        src_pulse = '0; nmi_pulse = 1'b0; sw_set = '0; sw_clr = '0;
        mask_wr = 1'b0; prio_wr = 1'b0; ie_set = 1'b0; ie_clr = 1'b0;
        irq_ack = 1'b0; reti = 1'b0;
        compare();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 pend", int'(pend), 0);
        chk("R11 wake", int'(wake), 0);
        chk("R11 valid", int'(irq_valid), 0);
        chk("R11 ie", int'(ie_o), 0);

        // R1 R3: two pulses into a masked source
        src_pulse[3] = 1'b1; cyc();
        src_pulse[3] = 1'b1; cyc();
        chk("R3 masked no wake", int'(wake), 0);
        chk("R1 single pending bit", int'(pend), 8);
        mask_wr = 1'b1; mask_wdata = '0; cyc();
        chk("R3 unmask wakes", int'(wake), 1);
        chk("R5 no offer while disabled", int'(irq_valid), 0);
        ie_set = 1'b1; cyc();
        chk("R6 vector 3", int'(irq_vec), 3);
        irq_ack = 1'b1; cyc();
        chk("R1 merged event gone", int'(irq_valid), 0);
        chk("R8 ie forced off", int'(ie_o), 0);
        reti = 1'b1; cyc();
        chk("R9 ie restored on", int'(ie_o), 1);

        // R6 R7 R9 ordering and nesting
        prio_wr = 1'b1; prio_wdata = 8'b0110_0000; cyc();
        src_pulse = 8'b0110_0100; cyc();
        chk("R6 high level first", int'(irq_vec), 5);
        irq_ack = 1'b1; cyc();
        ie_set = 1'b1; cyc();
        chk("R7 equal level blocked", int'(irq_valid), 0);
        reti = 1'b1; cyc();
        chk("R9 next high offered", int'(irq_vec), 6);
        irq_ack = 1'b1; cyc();
        reti = 1'b1; cyc();
        chk("R6 low after high", int'(irq_vec), 2);
        irq_ack = 1'b1; cyc();
        nmi_pulse = 1'b1; cyc();
        chk("R10 nmi ignores enable", int'(irq_vec), N);
        irq_ack = 1'b1; cyc();
        ie_set = 1'b1; src_pulse[5] = 1'b1; cyc();
        chk("R10 nmi in service blocks", int'(irq_valid), 0);
        reti = 1'b1; cyc();
        chk("R9 ie restored off", int'(ie_o), 0);
        ie_set = 1'b1; cyc();
        chk("R7 high nests over low", int'(irq_vec), 5);
        irq_ack = 1'b1; cyc();
        reti = 1'b1; cyc();
        reti = 1'b1; cyc();

        // R2 collisions
        sw_set[4] = 1'b1; sw_clr[4] = 1'b1; cyc();
        chk("R2 set beats clear", int'(pend[4]), 1);
        sw_clr[4] = 1'b1; cyc();
        chk("R2 clear", int'(pend[4]), 0);
        sw_clr[4] = 1'b1; src_pulse[4] = 1'b1; cyc();
        chk("R2 pulse beats clear", int'(pend[4]), 1);
        ie_set = 1'b1; cyc();
        irq_ack = 1'b1; src_pulse[4] = 1'b1; cyc();
        chk("R2 pulse beats ack clear", int'(pend[4]), 1);
        reti = 1'b1; cyc();

        // R10 nmi ignores mask
        mask_wr = 1'b1; mask_wdata = '1; ie_clr = 1'b1; cyc();
        sw_clr = '1; cyc();
        nmi_pulse = 1'b1; cyc();
        chk("R10 nmi wakes while masked", int'(wake), 1);
        irq_ack = 1'b1; cyc();
        reti = 1'b1; cyc();

        // Random mix against the model
        for (int n = 0; n < RAND_CYC; n++) begin
            for (int i = 0; i < N; i++) begin
                src_pulse[i] = ($urandom % 16) == 0;
                sw_set[i]    = ($urandom % 64) == 0;
                sw_clr[i]    = ($urandom % 32) == 0;
            end
            nmi_pulse  = ($urandom % 64) == 0;
            mask_wr    = ($urandom % 20) == 0;
            mask_wdata = N'($urandom);
            prio_wr    = ($urandom % 20) == 0;
            prio_wdata = N'($urandom);
            ie_set     = ($urandom % 8) == 0;
            ie_clr     = ($urandom % 16) == 0;
            irq_ack    = (m_pick() >= 0) && (($urandom % 2) == 0);
            reti       = !irq_ack && (m_cur() > 0) && (($urandom % 6) == 0);
            cyc();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule